// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of an integer ALU in a single combinational pass. It has two operand paths. The register path shifts a 32-bit value by an amount taken from a 5-bit field or from the low byte of a register word, under a 3-bit kind code. The immediate path widens an 8-bit constant and rotates it right by twice a 4-bit field. Alongside the operand it returns the carry the shifter produced and a flag that says whether that carry is fresh or is just the incoming carry passed through.

The block holds no state and has no clock. A zero field in the shift-by-field codes is given a new meaning instead of "do nothing". For right shifts it means a full-width shift. For rotate it means a one-bit rotate through the carry. A true zero amount leaves both the value and the carry untouched.

Top module: `shf_operand_unit`

## Requirements
- R1: The kind code is decoded as follows. Bit 0 set takes the amount from the register byte, and bit 0 clear takes it from the 5-bit field. Bits [2:1] select the operation: 00 is logical left, 01 is logical right, 10 is arithmetic right, and 11 is rotate right.
- R2: With a field amount of 0, a logical right or arithmetic right shift is performed as a shift by 32.
- R3: A rotate with a field amount of 0 is a one-bit rotate through the carry. The incoming carry enters bit 31, bit 0 becomes the carry-out, and carry_valid is 1.
- R4: Only bits [7:0] of the register amount word count. For example, a word of 256 behaves as an amount of 0.
- R5: An effective amount of 0 returns the value unchanged, with carry_out equal to carry_in and carry_valid equal to 0. This covers a logical left shift with a field amount of 0 and any register-path code with a register amount byte of 0.
- R6: For amounts from 1 to 31, the result is the shifted value and carry_out is the last bit moved out: bit 32-n for a left shift and bit n-1 for right shifts and rotates.
- R7: A logical shift by exactly 32 gives 0, with a carry of bit 0 for a left shift and bit 31 for a right shift. A logical shift by more than 32 gives 0 with a carry of 0.
- R8: An arithmetic right shift by 32 or more fills every bit with bit 31, and the carry equals bit 31.
- R9: A rotate by a register amount that is a nonzero multiple of 32 returns the value unchanged, with the carry equal to bit 31. Any other register amount rotates by the amount modulo 32.
- R10: On the immediate path (imm_sel = 1), the 8-bit constant is zero-extended and rotated right by twice rot_field. If rot_field is 0, the carry passes through and carry_valid is 0. Otherwise, carry_out equals bit 31 of the result and carry_valid is 1.
- R11: carry_valid is 1 exactly when a shift or rotate by a nonzero effective amount, or a one-bit rotate through the carry, is performed. Whenever carry_valid is 0, carry_out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_sel | input | 1 | 1 selects the immediate path, 0 selects the register path |
| src_val | input | 32 | Value to shift on the register path |
| kind_code | input | 3 | Shift kind and amount source (R1) |
| amt_field | input | 5 | Field shift amount |
| amt_reg_word | input | 32 | Register word supplying the amount; only bits [7:0] are used |
| const_byte | input | 8 | Immediate constant |
| rot_field | input | 4 | Immediate rotate field; the rotation is twice this value |
| carry_in | input | 1 | Current carry flag |
| op2 | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Carry produced by the shifter, or carry_in when no shift occurs |
| carry_valid | output | 1 | 1 when carry_out was produced by a shift |

## Verification
The checker assumes that all inputs are driven to known values and that, on the immediate path, the register-path inputs may hold anything because they must have no effect. It also assumes that twice the largest rotate field stays below the data width, which the default sizes meet. The stimulus sweeps every kind code and every field amount. It also sweeps every register amount byte from 0 to 299, plus words whose upper bits are set, and every rotate field on the immediate path, all over a handful of values with the sign bit and the low bit in both states. Expected values come from a one-bit-at-a-time reference loop in the bench.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // resolved operation after the amount encoding has been decoded
    typedef enum logic [2:0] {
        SK_NONE,
        SK_LSL,
        SK_LSR,
        SK_ASR,
        SK_ROR,
        SK_RRX
    } shf_kind_e;

    // operation field of the kind code, bits [2:1]
    localparam logic [1:0] OPF_LSL = 2'b00;
    localparam logic [1:0] OPF_LSR = 2'b01;
    localparam logic [1:0] OPF_ASR = 2'b10;
    localparam logic [1:0] OPF_ROR = 2'b11;

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_W   = 5,
    parameter int REG_AMT_W = 8,
    localparam int EFF_W    = (REG_AMT_W > $clog2(DATA_W) + 1) ? REG_AMT_W : $clog2(DATA_W) + 1
) (
    input  logic [2:0]           kind_code,
    input  logic [FIELD_W-1:0]   amt_field,
    input  logic [REG_AMT_W-1:0] amt_byte,
    output shf_kind_e            kind,
    output logic [EFF_W-1:0]     amt
);

    logic       by_reg;
    logic [1:0] opf;

    assign by_reg = kind_code[0];
    assign opf    = kind_code[2:1];

    always_comb begin
        kind = SK_NONE;
        amt  = '0;
        if (by_reg) begin
            amt = EFF_W'(amt_byte);
            unique case (opf)
                OPF_LSL: kind = SK_LSL;
                OPF_LSR: kind = SK_LSR;
                OPF_ASR: kind = SK_ASR;
                OPF_ROR: kind = SK_ROR;
                default: kind = SK_NONE;
            endcase
            if (amt_byte == '0) kind = SK_NONE;
        end else begin
            amt = EFF_W'(amt_field);
            unique case (opf)
                OPF_LSL: kind = (amt_field == '0) ? SK_NONE : SK_LSL;
                OPF_LSR: kind = SK_LSR;
                OPF_ASR: kind = SK_ASR;
                OPF_ROR: kind = (amt_field == '0) ? SK_RRX : SK_ROR;
                default: kind = SK_NONE;
            endcase
            // zero field on right shifts stands for a full-width shift
            if (amt_field == '0 && (opf == OPF_LSR || opf == OPF_ASR))
                amt = EFF_W'(DATA_W);
        end
    end

endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EFF_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  shf_kind_e          kind,
    input  logic [EFF_W-1:0]   amt,
    input  logic [DATA_W-1:0]  val,
    input  logic               cin,
    output logic [DATA_W-1:0]  res,
    output logic               cout,
    output logic               cvalid
);

    logic [DATA_W:0]   lsl_w;
    logic [DATA_W:0]   lsr_w;
    logic [DATA_W:0]   asr_w;
    logic [EFF_W-1:0]  asr_amt;
    logic [IDX_W-1:0]  ror_amt;
    logic [DATA_W-1:0] ror_r;

    // one extra bit beyond the value catches the last bit moved out
    assign lsl_w   = {1'b0, val} << amt;
    assign lsr_w   = {val, 1'b0} >> amt;
    assign asr_amt = (amt > EFF_W'(DATA_W)) ? EFF_W'(DATA_W) : amt;
    assign asr_w   = $signed({val, 1'b0}) >>> asr_amt;
    assign ror_amt = amt[IDX_W-1:0];
    assign ror_r   = DATA_W'({val, val} >> ror_amt);

    always_comb begin
        res    = val;
        cout   = cin;
        cvalid = 1'b0;
        unique case (kind)
            SK_NONE: begin
                res    = val;
                cout   = cin;
                cvalid = 1'b0;
            end
            SK_LSL: begin
                res    = lsl_w[DATA_W-1:0];
                cout   = lsl_w[DATA_W];
                cvalid = 1'b1;
            end
            SK_LSR: begin
                res    = lsr_w[DATA_W:1];
                cout   = lsr_w[0];
                cvalid = 1'b1;
            end
            SK_ASR: begin
                res    = asr_w[DATA_W:1];
                cout   = asr_w[0];
                cvalid = 1'b1;
            end
            SK_ROR: begin
                res    = ror_r;
                cout   = ror_r[DATA_W-1];
                cvalid = 1'b1;
            end
            SK_RRX: begin
                res    = {cin, val[DATA_W-1:1]};
                cout   = val[0];
                cvalid = 1'b1;
            end
            default: begin
                res    = val;
                cout   = cin;
                cvalid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shf_imm_rotate.sv
module shf_imm_rotate #(
    parameter int DATA_W  = 32,
    parameter int CONST_W = 8,
    parameter int ROT_W   = 4
) (
    input  logic [CONST_W-1:0] const_byte,
    input  logic [ROT_W-1:0]   rot_field,
    input  logic               cin,
    output logic [DATA_W-1:0]  res,
    output logic               cout,
    output logic               cvalid
);

    logic [DATA_W-1:0] widened;
    logic [ROT_W:0]    rsh;
    logic [DATA_W-1:0] rotated;

    assign widened = DATA_W'(const_byte);
    assign rsh     = {rot_field, 1'b0};
    assign rotated = DATA_W'({widened, widened} >> rsh);

    always_comb begin
        if (rot_field == '0) begin
            res    = widened;
            cout   = cin;
            cvalid = 1'b0;
        end else begin
            res    = rotated;
            cout   = rotated[DATA_W-1];
            cvalid = 1'b1;
        end
    end

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FIELD_W   = 5,
    parameter int REG_AMT_W = 8,
    parameter int CONST_W   = 8,
    parameter int ROT_W     = 4
) (
    input  logic                 imm_sel,
    input  logic [DATA_W-1:0]    src_val,
    input  logic [2:0]           kind_code,
    input  logic [FIELD_W-1:0]   amt_field,
    input  logic [DATA_W-1:0]    amt_reg_word,
    input  logic [CONST_W-1:0]   const_byte,
    input  logic [ROT_W-1:0]     rot_field,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    op2,
    output logic                 carry_out,
    output logic                 carry_valid
);

    localparam int EFF_W = (REG_AMT_W > $clog2(DATA_W) + 1) ? REG_AMT_W : $clog2(DATA_W) + 1;

    shf_kind_e         dec_kind;
    logic [EFF_W-1:0]  dec_amt;
    logic [DATA_W-1:0] reg_res;
    logic              reg_cout;
    logic              reg_cv;
    logic [DATA_W-1:0] imm_res;
    logic              imm_cout;
    logic              imm_cv;
    logic              unused_amt_hi;

    // only the low byte of the amount word takes part
    assign unused_amt_hi = ^amt_reg_word[DATA_W-1:REG_AMT_W];

    shf_amount_decode #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W), .REG_AMT_W(REG_AMT_W)
    ) u_dec (
        .kind_code(kind_code),
        .amt_field(amt_field),
        .amt_byte (amt_reg_word[REG_AMT_W-1:0]),
        .kind     (dec_kind),
        .amt      (dec_amt)
    );

    shf_core #(
        .DATA_W(DATA_W), .EFF_W(EFF_W)
    ) u_core (
        .kind  (dec_kind),
        .amt   (dec_amt),
        .val   (src_val),
        .cin   (carry_in),
        .res   (reg_res),
        .cout  (reg_cout),
        .cvalid(reg_cv)
    );

    shf_imm_rotate #(
        .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
    ) u_imm (
        .const_byte(const_byte),
        .rot_field (rot_field),
        .cin       (carry_in),
        .res       (imm_res),
        .cout      (imm_cout),
        .cvalid    (imm_cv)
    );

    always_comb begin
        if (imm_sel) begin
            op2         = imm_res;
            carry_out   = imm_cout;
            carry_valid = imm_cv;
        end else begin
            op2         = reg_res;
            carry_out   = reg_cout;
            carry_valid = reg_cv;
        end
    end

endmodule

// File: rtl/shf_operand_checker.sv
module shf_operand_checker #(
    parameter int DATA_W    = 32,
    parameter int FIELD_W   = 5,
    parameter int REG_AMT_W = 8,
    parameter int CONST_W   = 8,
    parameter int ROT_W     = 4
) (
    input logic                 imm_sel,
    input logic [DATA_W-1:0]    src_val,
    input logic [2:0]           kind_code,
    input logic [FIELD_W-1:0]   amt_field,
    input logic [DATA_W-1:0]    amt_reg_word,
    input logic [CONST_W-1:0]   const_byte,
    input logic [ROT_W-1:0]     rot_field,
    input logic                 carry_in,
    input logic [DATA_W-1:0]    op2,
    input logic                 carry_out,
    input logic                 carry_valid
);

    logic [REG_AMT_W-1:0] byte_amt;
    assign byte_amt = amt_reg_word[REG_AMT_W-1:0];

    always_comb begin
        if (!carry_valid)
            AST_CARRY_PASS: assert (carry_out == carry_in) else $error("carry not passed"); // R11
        if (!imm_sel && kind_code[0] && byte_amt == '0)
            AST_ZERO_AMT_HOLD: assert (op2 == src_val && !carry_valid) else $error("zero amount moved"); // R5
        if (!imm_sel && kind_code[0] && kind_code[2] == 1'b0 && byte_amt > REG_AMT_W'(DATA_W))
            AST_LOGIC_FLUSH: assert (op2 == '0 && !carry_out) else $error("flush wrong"); // R7
        if (!imm_sel && kind_code == 3'b101 && byte_amt >= REG_AMT_W'(DATA_W))
            AST_ARITH_FILL: assert (op2 == {DATA_W{src_val[DATA_W-1]}} && carry_out == src_val[DATA_W-1])
                else $error("sign fill wrong"); // R8
        if (!imm_sel && kind_code == 3'b110 && amt_field == '0)
            AST_RRX_TOP: assert (op2[DATA_W-1] == carry_in && carry_out == src_val[0]) else $error("rrx wrong"); // R3
        if (imm_sel && rot_field == '0)
            AST_IMM_PLAIN: assert (op2 == DATA_W'(const_byte) && !carry_valid) else $error("plain imm wrong"); // R10
        if (imm_sel && rot_field != '0)
            AST_IMM_ROT_CARRY: assert (carry_valid && carry_out == op2[DATA_W-1]) else $error("imm carry wrong"); // R10
    end

endmodule

bind shf_operand_unit shf_operand_checker #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .REG_AMT_W(REG_AMT_W),
    .CONST_W(CONST_W), .ROT_W(ROT_W)
) u_chk (
    .imm_sel     (imm_sel),
    .src_val     (src_val),
    .kind_code   (kind_code),
    .amt_field   (amt_field),
    .amt_reg_word(amt_reg_word),
    .const_byte  (const_byte),
    .rot_field   (rot_field),
    .carry_in    (carry_in),
    .op2         (op2),
    .carry_out   (carry_out),
    .carry_valid (carry_valid)
);

// File: tb/sim_shf_operand_unit.sv
module sim_shf_operand_unit;

    logic        clk = 1'b0;
    logic        imm_sel;
    logic [31:0] src_val;
    logic [2:0]  kind_code;
    logic [4:0]  amt_field;
    logic [31:0] amt_reg_word;
    logic [7:0]  const_byte;
    logic [3:0]  rot_field;
    logic        carry_in;
    logic [31:0] op2;
    logic        carry_out;
    logic        carry_valid;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    shf_operand_unit u0 (
        .imm_sel(imm_sel), .src_val(src_val), .kind_code(kind_code),
        .amt_field(amt_field), .amt_reg_word(amt_reg_word),
        .const_byte(const_byte), .rot_field(rot_field), .carry_in(carry_in),
        .op2(op2), .carry_out(carry_out), .carry_valid(carry_valid)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
        end
    endtask

    // reference: move one bit at a time, per the requirements
    task automatic model(output logic [31:0] r, output logic c, output logic v);
        logic [31:0] x;
        int n;
        x = imm_sel ? {24'd0, const_byte} : src_val;
        c = carry_in;
        v = 1'b0;
        if (imm_sel) begin
            for (int k = 0; k < 2 * rot_field; k++) x = {x[0], x[31:1]};
            if (rot_field != 0) begin c = x[31]; v = 1'b1; end
        end else begin
            n = kind_code[0] ? int'(amt_reg_word[7:0]) : int'(amt_field);
            if (!kind_code[0] && n == 0 && kind_code[2:1] != 2'b00) n = 32;
            if (kind_code == 3'b110 && amt_field == 0) begin
                c = src_val[0];
                x = {carry_in, src_val[31:1]};
                v = 1'b1;
            end else begin
                for (int k = 0; k < n; k++) begin
                    case (kind_code[2:1])
                        2'b00: begin c = x[31]; x = x << 1; end
                        2'b01: begin c = x[0]; x = x >> 1; end
                        2'b10: begin c = x[0]; x = {x[31], x[31:1]}; end
                        default: begin c = x[0]; x = {x[0], x[31:1]}; end
                    endcase
                end
                v = (n != 0);
            end
        end
        r = x;
    endtask

    task automatic apply(input string tag);
        logic [31:0] er;
        logic ec, ev;
        @(negedge clk);
        #1;
        model(er, ec, ev);
        chk(tag, "op2", op2, er);
        chk(tag, "carry_out", {31'd0, carry_out}, {31'd0, ec});
        chk("R11", "carry_valid", {31'd0, carry_valid}, {31'd0, ev});
    endtask

    function automatic string reg_tag(input logic [2:0] k, input logic [31:0] w);
        int n = int'(w[7:0]);
        if (w[31:8] != 0) return "R4";
        if (n == 0) return "R5";
        if (k[2:1] == 2'b10 && n >= 32) return "R8";
        if (k[2:1] == 2'b11 && n >= 32 && n % 32 == 0) return "R9";
        if (k[2] == 1'b0 && n >= 32) return "R7";
        return "R6";
    endfunction

    function automatic string fld_tag(input logic [2:0] k, input logic [4:0] a);
        if (a != 0) return (a[0] ? "R6" : "R1");
        if (k[2:1] == 2'b00) return "R5";
        if (k[2:1] == 2'b11) return "R3";
        return "R2";
    endfunction

    logic [31:0] vals [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                              32'h7F3C_A5E1, 32'h1234_5678, 32'h8421_0F0F};
    logic [31:0] extra [5] = '{32'h0000_0100, 32'h0000_0101, 32'h0000_0120,
                               32'h0000_0121, 32'hABCD_0007};

    initial begin
        imm_sel = 0; src_val = 0; kind_code = 0; amt_field = 0;
        amt_reg_word = 0; const_byte = 0; rot_field = 0; carry_in = 0;
        @(negedge clk); #1;
        // idle inputs: value passes, no fresh carry
        chk("R5", "idle op2", op2, 32'd0);
        chk("R5", "idle carry_valid", {31'd0, carry_valid}, 32'd0);

        for (int vi = 0; vi < 6; vi++) begin
            for (int ci = 0; ci < 2; ci++) begin
                src_val  = vals[vi];
                carry_in = ci[0];
                imm_sel  = 0;
                // field-amount codes, every amount
                for (int k = 0; k < 8; k += 2) begin
                    for (int a = 0; a < 32; a++) begin
                        kind_code = 3'(k); amt_field = 5'(a);
                        amt_reg_word = 32'hFFFF_FFFF;   // must not matter here
                        apply(fld_tag(3'(k), 5'(a)));
                    end
                end
                // register-amount codes
                for (int k = 1; k < 8; k += 2) begin
                    kind_code = 3'(k);
                    amt_field = 5'd17;                  // must not matter here
                    for (int a = 0; a < 300; a++) begin
                        amt_reg_word = 32'(a);
                        apply(reg_tag(3'(k), 32'(a)));
                    end
                    for (int e = 0; e < 5; e++) begin
                        amt_reg_word = extra[e];
                        apply(reg_tag(3'(k), extra[e]));
                    end
                end
                // immediate path
                imm_sel = 1;
                for (int r = 0; r < 16; r++) begin
                    rot_field  = 4'(r);
                    const_byte = vals[vi][7:0] ^ 8'(r * 37);
                    apply("R10");
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule